// File: doc/BRIEF.md
# Multi-Output Programmable Clock Divider

This block divides one reference clock into a bank of gated output clocks and one internal processing clock that never stops. Every output has its own 2-bit ratio code that picks an even divisor of 4, 6, 8 or 10. Because each output spends exactly half its period high and half low, every output has a 50% duty cycle. All dividers count reference-clock cycles and are registered in the reference domain, so the outputs leave the block as glitch-free registered levels.

A single 32-bit control word sets the enables and the ratio codes. A simple bus port writes and reads this word at one address. A new setting is not applied to a running output straight away. The output takes it up only when it next falls, so the high phase already in progress always completes at its old length, and no runt pulse can appear. An output whose enable is clear stays low. Reset drives every output low. After reset, all outputs are enabled and divide by 10.

Top module: `clkdiv_bank`

## Requirements
- R1: Ratio code 00 gives a divide-by-4 output, 01 gives divide-by-6, 10 gives divide-by-8 and 11 gives divide-by-10. Each output is high for half the period and low for the other half: 2, 3, 4 or 5 reference cycles respectively.
- R2: When the enable bit of gated output k (control bit 4k) has been taken up as 0, out_clk[k] stays low.
- R3: While rst_n is low, every output is low and the control word reads back 0x0006_7777. After reset, every output first stays low for 5 cycles and then runs at divide-by-10.
- R4: The control word sits at bus address 0x10. For gated output k, the enable is bit 4k and the ratio code is bits 4k+2:4k+1. The internal clock's ratio code is bits 18:17. A write is visible on bus_rdata in the cycle after the write edge.
- R5: Bits 3, 7, 11, 15, 16 and 31:19 are reserved. They read back as 0, and writing 1 to them has no effect on any output.
- R6: A write to any address other than 0x10 leaves the control word unchanged. A read from any address other than 0x10 returns 0.
- R7: A new ratio or enable for a running output takes effect only at that output's next falling edge. The high phase in progress finishes at its old length, and the next low phase uses the new length.
- R8: int_clk runs at all times outside reset, whatever the gated enables hold. It divides by the code in bits 18:17.
- R9: An output that is idle because it is disabled takes up a new setting one cycle after the write edge. It then stays low for one full new half period before it first rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational from bus_addr |
| out_clk | output | 4 | Gated divided clock outputs |
| int_clk | output | 1 | Always-on internal divided clock |

## Verification
A write lands in the control word on the edge where bus_wr is sampled, and is readable on bus_rdata in the next cycle. A running output switches to the new setting only on the edge where it falls. An idle output takes the setting up one edge after the write, and rises one half period after that. The bench keeps a behavioural model that steps once on every rising edge from the same inputs and follows these rules. It compares all five outputs against the model at every falling edge. Because outputs only ever change on rising edges, each comparison falls in the middle of a stable cycle. Readback checks drive the address at a falling edge and sample one time unit later.

// File: rtl/clkdiv_pkg.sv
// Package: shared field layout and helpers for the clock divider bank.
// Assumes at most four gated outputs with a 4-bit field stride, and the
// internal clock ratio code at bits 18:17 of a 32-bit control word.
package clkdiv_pkg;

    localparam int CFG_W        = 32;
    localparam int SEL_W        = 2;
    localparam int CNT_W        = 3;
    localparam int FIELD_STRIDE = 4;
    localparam int INT_SEL_LSB  = 17;

    // Half period in reference cycles for a ratio code: 2, 3, 4 or 5.
    function automatic logic [CNT_W-1:0] half_cycles(input logic [SEL_W-1:0] sel);
        return CNT_W'(2) + CNT_W'(sel);
    endfunction

    // Mask of implemented (writable) control bits for n gated outputs.
    function automatic logic [CFG_W-1:0] cfg_mask(input int n);
        logic [CFG_W-1:0] m;
        m = '0;
        for (int k = 0; k < n; k++) begin
            m[FIELD_STRIDE*k +: 3] = 3'b111;
        end
        m[INT_SEL_LSB +: SEL_W] = '1;
        return m;
    endfunction

    // Reset value: all outputs enabled, all ratio codes 11.
    function automatic logic [CFG_W-1:0] cfg_reset(input int n);
        return cfg_mask(n);
    endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
// Control word register with a simple write-strobe / combinational-read
// bus port. Assumes one decoded address; unimplemented bits are forced to
// zero on write, so they always read back as zero.
module clkdiv_ctrl_reg #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
    parameter logic [DATA_W-1:0] RST_VAL  = '0,
    parameter logic [DATA_W-1:0] WMASK    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cfg_q
);

    logic hit;

    // Address decode for the single control word.
    assign hit = (bus_addr == REG_ADDR);

    // Register update: reset value, then masked writes on address hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else if (bus_wr && hit) begin
            cfg_q <= bus_wdata & WMASK;
        end
    end

    // Read mux: the control word on hit, zero elsewhere.
    always_comb begin
        bus_rdata = hit ? cfg_q : '0;
    end

endmodule

// File: rtl/clkdiv_unit.sv
// One divider: counts half periods of the active ratio and toggles its
// output. The pending enable and ratio are taken up only as the output
// falls, or on any cycle while the unit is idle, so the high phase in
// progress always completes. Assumes the cfg inputs are in the clk domain.
module clkdiv_unit
    import clkdiv_pkg::*;
#(
    parameter logic             RST_EN  = 1'b1,
    parameter logic [SEL_W-1:0] RST_SEL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             div_q
);

    logic             act_en;
    logic [SEL_W-1:0] act_sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count of the current half period.
    always_comb begin
        last = half_cycles(act_sel) - CNT_W'(1);
    end

    // Half-period counter, output toggle and falling-edge settings pickup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= 1'b0;
            cnt     <= '0;
            act_en  <= RST_EN;
            act_sel <= RST_SEL;
        end else if (!act_en) begin
            div_q   <= 1'b0;
            cnt     <= '0;
            act_en  <= cfg_en;
            act_sel <= cfg_sel;
        end else if (cnt == last) begin
            cnt   <= '0;
            div_q <= ~div_q;
            if (div_q) begin
                act_en  <= cfg_en;
                act_sel <= cfg_sel;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/clkdiv_bank.sv
// Top: control word plus a bank of gated dividers and one always-on
// internal divider. Assumes NUM_OUT <= 4 so the fields fit below bit 16.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                NUM_OUT  = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CFG_W-1:0]  bus_wdata,
    output logic [CFG_W-1:0]  bus_rdata,
    output logic [NUM_OUT-1:0] out_clk,
    output logic              int_clk
);

    localparam logic [CFG_W-1:0] WMASK   = cfg_mask(NUM_OUT);
    localparam logic [CFG_W-1:0] RST_VAL = cfg_reset(NUM_OUT);

    logic [CFG_W-1:0] cfg_q;

    clkdiv_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (CFG_W),
        .REG_ADDR (REG_ADDR),
        .RST_VAL  (RST_VAL),
        .WMASK    (WMASK)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_q     (cfg_q)
    );

    // One gated divider per output, fields at a fixed stride.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        clkdiv_unit #(
            .RST_EN  (RST_VAL[FIELD_STRIDE*k]),
            .RST_SEL (RST_VAL[FIELD_STRIDE*k+1 +: SEL_W])
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_en  (cfg_q[FIELD_STRIDE*k]),
            .cfg_sel (cfg_q[FIELD_STRIDE*k+1 +: SEL_W]),
            .div_q   (out_clk[k])
        );
    end

    // Internal processing clock: enable tied high.
    clkdiv_unit #(
        .RST_EN  (1'b1),
        .RST_SEL (RST_VAL[INT_SEL_LSB +: SEL_W])
    ) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (1'b1),
        .cfg_sel (cfg_q[INT_SEL_LSB +: SEL_W]),
        .div_q   (int_clk)
    );

endmodule

// File: rtl/clkdiv_bank_chk.sv
// Checker bound to clkdiv_bank: port-level properties on run lengths,
// reset state and readback. Assumes the default field layout.
module clkdiv_bank_chk
    import clkdiv_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                NUM_OUT  = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [CFG_W-1:0]   bus_wdata,
    input logic [CFG_W-1:0]   bus_rdata,
    input logic [NUM_OUT-1:0] out_clk,
    input logic               int_clk
);

    localparam logic [CFG_W-1:0] WMASK = cfg_mask(NUM_OUT);
    localparam int               NSIG  = NUM_OUT + 1;

    logic [NSIG-1:0] sig;
    logic [NSIG-1:0] prev;
    logic [3:0]      run [NSIG];

    assign sig = {int_clk, out_clk};

    // Track the previous level and the length of the current run per output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            for (int i = 0; i < NSIG; i++) run[i] <= '0;
        end else begin
            prev <= sig;
            for (int i = 0; i < NSIG; i++) begin
                if (sig[i] != prev[i]) run[i] <= 4'd1;
                else if (run[i] != 4'hF) run[i] <= run[i] + 4'd1;
            end
        end
    end

    // R1 and R7: every high phase lasts 2 to 5 cycles, so there are no runt pulses.
    for (genvar i = 0; i < NSIG; i++) begin : g_run
        a_r7_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
            (prev[i] && !sig[i]) |-> (run[i] >= 4'd2 && run[i] <= 4'd5));
    end

    // R8: the internal clock never holds a level for more than 5 cycles.
    a_r8_int_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (run[NSIG-1] <= 4'd5));

    // R3: every output is low on the first cycle after reset is released.
    a_r3_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_clk == '0 && !int_clk));

    // R5: reserved bits always read back as zero.
    a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~WMASK) == '0));

    // R4: a write is readable, masked, in the following cycle.
    a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR) |=>
        (bus_addr != REG_ADDR || bus_rdata == ($past(bus_wdata) & WMASK)));

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_OUT  (NUM_OUT),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .out_clk   (out_clk),
    .int_clk   (int_clk)
);

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;

    localparam int NOUT = 4;
    localparam logic [31:0] MASK = 32'h0006_7777;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NOUT-1:0] out_clk;
    logic        int_clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    string cur_req = "R3";
    bit started = 0;

    // Behavioural model state: index NOUT is the internal clock.
    logic [31:0] m_cfg;
    int m_q   [NOUT+1];
    int m_cnt [NOUT+1];
    int m_en  [NOUT+1];
    int m_half[NOUT+1];

    always #2.5 clk = ~clk;   // 200 MHz

    clkdiv_bank u_clkdiv_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .out_clk   (out_clk),
        .int_clk   (int_clk)
    );

    function automatic int cfg_en_of(logic [31:0] c, int i);
        return (i == NOUT) ? 1 : int'(c[4*i]);
    endfunction

    function automatic int cfg_half_of(logic [31:0] c, int i);
        int sel;
        sel = (i == NOUT) ? int'(c[18:17]) : int'((c >> (4*i+1)) & 3);
        return 2 + sel;
    endfunction

    // Model step on every rising edge, from the bench's own inputs.
    always @(posedge clk) begin
        cyc++;
        started = 1;
        for (int i = 0; i <= NOUT; i++) begin
            if (!rst_n) begin
                m_q[i] = 0; m_cnt[i] = 0; m_en[i] = 1; m_half[i] = 5;
            end else if (m_en[i] == 0) begin
                m_q[i] = 0; m_cnt[i] = 0;
                m_en[i] = cfg_en_of(m_cfg, i);
                m_half[i] = cfg_half_of(m_cfg, i);
            end else if (m_cnt[i] == m_half[i] - 1) begin
                m_cnt[i] = 0;
                if (m_q[i] == 1) begin
                    m_q[i] = 0;
                    m_en[i] = cfg_en_of(m_cfg, i);
                    m_half[i] = cfg_half_of(m_cfg, i);
                end else begin
                    m_q[i] = 1;
                end
            end else begin
                m_cnt[i] = m_cnt[i] + 1;
            end
        end
        if (!rst_n) m_cfg = MASK;
        else if (bus_wr && bus_addr == 8'h10) m_cfg = bus_wdata & MASK;
    end

    // Compare all outputs with the model mid-cycle.
    always @(negedge clk) begin
        if (started) begin
            for (int i = 0; i <= NOUT; i++) begin
                logic act;
                act = (i == NOUT) ? int_clk : out_clk[i];
                checks++;
                if (act !== m_q[i][0]) begin
                    errors++;
                    $display("FAIL %s output %0d at cycle %0d: actual=%b expected=%0d",
                             cur_req, i, cyc, act, m_q[i]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h10;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h: actual=0x%08h expected=0x%08h", req, a, bus_rdata, exp);
        end
        bus_addr = 8'h10;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R3: reset state and divide-by-10 start-up.
        cur_req = "R3";
        idle(4);
        rd_chk(8'h10, 32'h0006_7777, "R3");
        @(negedge clk) rst_n = 1'b1;
        idle(40);

        // R1: a distinct ratio on each output, internal at divide-by-4.
        cur_req = "R1";
        wr(8'h10, 32'h0000_7531);
        idle(90);

        // R7: change the ratios mid-phase, including back-to-back writes.
        cur_req = "R7";
        wr(8'h10, 32'h0006_1357);
        idle(3);
        wr(8'h10, 32'h0002_3333);
        wr(8'h10, 32'h0004_5555);
        idle(7);
        wr(8'h10, 32'h0006_7777);
        idle(60);

        // R2: disable outputs 1 and 3.
        cur_req = "R2";
        wr(8'h10, 32'h0002_0501);
        idle(70);

        // R9: re-enable idle outputs with new ratios.
        cur_req = "R9";
        wr(8'h10, 32'h0002_3531);
        idle(70);

        // R8: all gated outputs off; the internal clock keeps running.
        cur_req = "R8";
        wr(8'h10, 32'h0000_0000);
        idle(50);
        wr(8'h10, 32'h0006_0000);
        idle(50);

        // R5: reserved bits read zero and leave the outputs unchanged.
        cur_req = "R5";
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h0006_7777, "R5");
        wr(8'h10, 32'hFFF9_8888);
        rd_chk(8'h10, 32'h0000_0000, "R5");
        idle(30);

        // R6: other addresses are neither written nor read.
        cur_req = "R6";
        wr(8'h10, 32'h0000_3333);
        wr(8'h14, 32'h0006_7777);
        rd_chk(8'h10, 32'h0000_3333, "R6");
        rd_chk(8'h14, 32'h0000_0000, "R6");
        rd_chk(8'h00, 32'h0000_0000, "R6");
        idle(30);

        // R4: field layout readback and its effect on each output.
        cur_req = "R4";
        wr(8'h10, 32'h0004_2345);
        rd_chk(8'h10, 32'h0004_2345, "R4");
        idle(60);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule